// File: doc/BRIEF.md
# Serial Flash Buffered Page-Program Engine

This block drives the write side of a single-lane serial NOR flash port. Software chooses between two write modes. In buffered mode it pushes 32-bit words into a word queue. Once a full 128-byte page is queued, one write command sends the program opcode, the address and the whole page inside a single chip-select window. In direct mode the same command sends the opcode, the address and one data byte taken from a byte input.

A mode request input selects buffered operation. The mode acknowledge output reports the mode the engine actually uses, and software waits for it to match before it writes. The busy output stays high for as long as a command runs and clears by itself when the window closes. A buffered command issued before the page is full sends nothing and raises an underfill flag instead.

The serial port works in SPI mode 0. Clock idle is low, data changes while the clock is low and is sampled on the rising edge. Each byte goes out most significant bit first, and one bit lasts two system clocks.

Top module: `flash_pp_wbuf`

## Requirements
- R1: After synchronous reset the outputs read as follows: `cs_n_o`=1, `sck_o`=0, `mosi_o`=0, `busy_o`=0, `underfill_o`=0 and `mode_ack_o`=0. `sck_o` is never high while `cs_n_o` is high.
- R2: While the block is idle, `mode_ack_o` takes the value of `mode_req_i` one clock after the request changes. While a command runs, `mode_ack_o` holds its value. A change requested during the command shows one clock after `busy_o` falls.
- R3: A buffered command sends the bytes in this order: the opcode, the address bytes, then 128 data bytes taken from 32 queued words. Each word gives bits 7:0 first, then 15:8, then 23:16, then 31:24. Every byte is shifted most significant bit first, data is valid on each rising `sck_o` edge, and `sck_o` is high for exactly one clock at a time.
- R4: With `addr4_i`=0 the address is sent as three bytes: bits 23:16, then 15:8, then 7:0. With `addr4_i`=1 bits 31:24 are sent first, for four bytes in total.
- R5: When `mode_ack_o`=0, a command sends the opcode, the address and the single byte on `single_byte_i`.
- R6: An accepted command raises `busy_o` and lowers `cs_n_o` on the next clock. Both stay that way for 16·N+2 clocks, where N is the number of bytes sent. `busy_o` is low whenever `cs_n_o` is high.
- R7: A `go_i` pulse with `mode_ack_o`=1 and fewer than 32 queued words sets `underfill_o`. In that case there is no chip-select activity and `busy_o` stays low. The next command that is accepted clears `underfill_o`.
- R8: When `mode_ack_o` goes low, the word queue is emptied.
- R9: A pushed word is dropped in three cases: `mode_ack_o` is low, 32 words are already queued, or a command is running.
- R10: A `go_i` pulse while `busy_o` is high is ignored. The running window keeps its length and its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 1 | Request for buffered mode |
| mode_ack_o | output | 1 | Mode in effect (1 = buffered) |
| push_i | input | 1 | Push strobe for the word queue |
| push_word_i | input | 32 | Word to queue, first flash byte in bits 7:0 |
| go_i | input | 1 | Start a write command |
| busy_o | output | 1 | Command running; clears itself at the end |
| underfill_o | output | 1 | Buffered command refused because the queue was short |
| opcode_i | input | 8 | Program opcode sent first |
| addr_i | input | 32 | Flash byte address |
| addr4_i | input | 1 | Send four address bytes instead of three |
| single_byte_i | input | 8 | Data byte for direct mode |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |

## Verification
Every output is a register, so each result is due at a fixed clock edge. `busy_o` and `cs_n_o` change one edge after `go_i` is sampled, and they return 16·N+2 edges later. `underfill_o` settles on the edge that samples `go_i`. `mode_ack_o` follows its request one edge later, or one edge after `busy_o` drops. The bench drives inputs and samples outputs on the falling clock edge. It rebuilds the serial stream from the rising `sck_o` transitions it sees at those samples, and counts busy and select-low samples so it can compare them with 16·N+2 exactly. Mode checks are placed in the sample right before and right after the edge at which the acknowledge is due.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_TAIL  = 2'd2,
    SQ_END   = 2'd3
  } seq_state_e;

  localparam int BYTE_BITS = 8;
  localparam int CLKS_PER_BYTE = 2 * BYTE_BITS;
  localparam int HDR_ADDR_SHORT = 3;
  localparam int HDR_ADDR_LONG  = 4;
endpackage

// File: rtl/flash_pp_mode.sv
module flash_pp_mode (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic hold_i,
  output logic mode_o
);
  logic mode_q;

  // Mode changes only between commands; held while a command runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
    end else if (!hold_i) begin
      mode_q <= req_i;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/flash_pp_fifo.sv
module flash_pp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] rdata_q;
  logic             do_wr, do_rd;

  assign do_wr = wr_i && !clr_i && (count_q != CW'(DEPTH));
  assign do_rd = rd_i && !clr_i && (count_q != '0);

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wptr_q] <= wdata_i;
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (do_rd) begin
      rdata_q <= mem[rptr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_wr) begin
        wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      end
      if (do_rd) begin
        rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      end
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign count_o = count_q;
endmodule

// File: rtl/flash_pp_shifter.sv
module flash_pp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [BITS-1:0] byte_i,
  output logic            last_o,
  output logic            sck_o,
  output logic            mosi_o
);
  localparam int BW = $clog2(BITS);

  logic [BITS-1:0] sh_q;
  logic [BW-1:0]   bit_q;
  logic            phase_q, active_q, sck_q, mosi_q;

  // High in the cycle that raises the clock for the final bit of the byte.
  assign last_o = active_q && phase_q && (bit_q == BW'(BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      bit_q    <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
    end else begin
      if (active_q) begin
        if (!phase_q) begin
          mosi_q  <= sh_q[BITS-1];
          sck_q   <= 1'b0;
          phase_q <= 1'b1;
        end else begin
          sck_q   <= 1'b1;
          phase_q <= 1'b0;
          sh_q    <= {sh_q[BITS-2:0], 1'b0};
          bit_q   <= bit_q + 1'b1;
          if (bit_q == BW'(BITS - 1)) begin
            active_q <= 1'b0;
          end
        end
      end else begin
        sck_q <= 1'b0;
      end
      // A new byte taken in the final-bit cycle keeps the bit stream gapless.
      if (load_i) begin
        sh_q     <= byte_i;
        bit_q    <= '0;
        phase_q  <= 1'b0;
        active_q <= 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/flash_pp_wbuf.sv
module flash_pp_wbuf #(
  parameter int BURST_BYTES = 128,
  parameter int WORD_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_req_i,
  output logic              mode_ack_o,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic              go_i,
  output logic              busy_o,
  output logic              underfill_o,
  input  logic [7:0]        opcode_i,
  input  logic [31:0]       addr_i,
  input  logic              addr4_i,
  input  logic [7:0]        single_byte_i,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o
);
  import flash_pp_pkg::*;

  localparam int BPW   = WORD_W / BYTE_BITS;
  localparam int DEPTH = BURST_BYTES / BPW;
  localparam int MAXN  = 1 + HDR_ADDR_LONG + BURST_BYTES;
  localparam int IW    = $clog2(MAXN + 1);
  localparam int LW    = $clog2(BPW);
  localparam int CW    = $clog2(DEPTH + 1);

  seq_state_e       state_q;
  logic             busy_q, err_q, cs_n_q;
  logic             mode_q, mode_r;
  logic [IW-1:0]    idx_q, total_q;
  logic [2:0]       alen_q;
  logic [31:0]      addr_r;
  logic [7:0]       byte_r;

  logic [CW-1:0]    fifo_count;
  logic [WORD_W-1:0] fifo_dout;
  logic             fifo_wr, fifo_rd;

  logic             ser_load, ser_last;
  logic [7:0]       ser_byte, next_byte;

  logic             accept, burst_ok, launch, refuse, step, more, in_data;
  logic [IW-1:0]    kpos, hdr_rem;
  logic [LW-1:0]    data_lane;
  logic [31:0]      addr_sh;

  flash_pp_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .req_i  (mode_req_i),
    .hold_i (busy_q),
    .mode_o (mode_q)
  );

  // Queue is held empty whenever buffered mode is off.
  flash_pp_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (!mode_q),
    .wr_i    (fifo_wr),
    .wdata_i (push_word_i),
    .rd_i    (fifo_rd),
    .rdata_o (fifo_dout),
    .count_o (fifo_count)
  );

  flash_pp_shifter #(.BITS(BYTE_BITS)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load_i (ser_load),
    .byte_i (ser_byte),
    .last_o (ser_last),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  assign accept   = go_i && (state_q == SQ_IDLE);
  assign burst_ok = (fifo_count == CW'(DEPTH));
  assign launch   = accept && (!mode_q || burst_ok);
  assign refuse   = accept && mode_q && !burst_ok;
  assign fifo_wr  = push_i && mode_q && !busy_q;

  assign step    = (state_q == SQ_SHIFT) && ser_last;
  assign more    = idx_q < total_q;
  assign in_data = idx_q > IW'(alen_q);
  assign kpos    = idx_q - IW'(1) - IW'(alen_q);
  assign hdr_rem = IW'(alen_q) - idx_q;
  assign data_lane = kpos[LW-1:0];
  assign addr_sh = addr_r >> {hdr_rem, 3'b000};

  // Byte selection for the next slot of the window.
  always_comb begin
    if (!in_data) begin
      next_byte = addr_sh[7:0];
    end else if (mode_r) begin
      next_byte = fifo_dout[{data_lane, 3'b000} +: 8];
    end else begin
      next_byte = byte_r;
    end
  end

  assign ser_load = launch || (step && more);
  assign ser_byte = launch ? opcode_i : next_byte;

  // First word is read at launch; each later one when the top lane of the
  // current word is handed to the shifter.
  assign fifo_rd = (launch && mode_q) ||
                   (step && more && mode_r && in_data &&
                    (data_lane == LW'(BPW - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      mode_r  <= 1'b0;
      idx_q   <= '0;
      total_q <= '0;
      alen_q  <= 3'(HDR_ADDR_SHORT);
      addr_r  <= '0;
      byte_r  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (launch) begin
            state_q <= SQ_SHIFT;
            busy_q  <= 1'b1;
            err_q   <= 1'b0;
            cs_n_q  <= 1'b0;
            mode_r  <= mode_q;
            idx_q   <= IW'(1);
            alen_q  <= addr4_i ? 3'(HDR_ADDR_LONG) : 3'(HDR_ADDR_SHORT);
            total_q <= IW'(1 + (addr4_i ? HDR_ADDR_LONG : HDR_ADDR_SHORT)
                           + (mode_q ? BURST_BYTES : 1));
            addr_r  <= addr_i;
            byte_r  <= single_byte_i;
          end else if (refuse) begin
            err_q <= 1'b1;
          end
        end
        SQ_SHIFT: begin
          if (step) begin
            if (more) begin
              idx_q <= idx_q + 1'b1;
            end else begin
              state_q <= SQ_TAIL;
            end
          end
        end
        SQ_TAIL: begin
          state_q <= SQ_END;
        end
        SQ_END: begin
          state_q <= SQ_IDLE;
          busy_q  <= 1'b0;
          cs_n_q  <= 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign mode_ack_o  = mode_q;
  assign busy_o      = busy_q;
  assign underfill_o = err_q;
  assign cs_n_o      = cs_n_q;
endmodule

// File: rtl/flash_pp_wbuf_chk.sv
module flash_pp_wbuf_chk #(
  parameter int BURST_BYTES = 128
) (
  input logic clk,
  input logic rst,
  input logic mode_ack_o,
  input logic busy_o,
  input logic underfill_o,
  input logic cs_n_o,
  input logic sck_o
);
  localparam int MAXN  = 1 + 4 + BURST_BYTES;
  localparam int LIMIT = 16 * MAXN + 2;
  localparam int RW    = $clog2(LIMIT + 2);

  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run <= '0;
    end else if (busy_o) begin
      busy_run <= busy_run + 1'b1;
    end else begin
      busy_run <= '0;
    end
  end

  assert_quiet_when_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(mode_ack_o));

  assert_sck_single_high_R3: assert property (@(posedge clk) disable iff (rst)
    sck_o |=> !sck_o);

  assert_idle_deselect_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> cs_n_o);

  assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (busy_run < RW'(LIMIT)));

  assert_underfill_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(underfill_o) |-> (cs_n_o && !busy_o));
endmodule

bind flash_pp_wbuf flash_pp_wbuf_chk #(.BURST_BYTES(BURST_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_ack_o  (mode_ack_o),
  .busy_o      (busy_o),
  .underfill_o (underfill_o),
  .cs_n_o      (cs_n_o),
  .sck_o       (sck_o)
);

// File: tb/sim_flash_pp_wbuf.sv
module sim_flash_pp_wbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_req = 1'b0;
  logic        push = 1'b0;
  logic [31:0] push_word = '0;
  logic        go = 1'b0;
  logic [7:0]  opcode = 8'h02;
  logic [31:0] addr = '0;
  logic        addr4 = 1'b0;
  logic [7:0]  sbyte = '0;
  logic        mode_ack, busy, underfill, cs_n, sck, mosi;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flash_pp_wbuf u0 (
    .clk           (clk),
    .rst           (rst),
    .mode_req_i    (mode_req),
    .mode_ack_o    (mode_ack),
    .push_i        (push),
    .push_word_i   (push_word),
    .go_i          (go),
    .busy_o        (busy),
    .underfill_o   (underfill),
    .opcode_i      (opcode),
    .addr_i        (addr),
    .addr4_i       (addr4),
    .single_byte_i (sbyte),
    .cs_n_o        (cs_n),
    .sck_o         (sck),
    .mosi_o        (mosi)
  );

  // Serial monitor: rebuilds bytes from rising sck seen at falling clk edges.
  logic [7:0] rx [0:4095];
  logic [7:0] acc = '0;
  int rx_n = 0, bitn = 0, busy_cnt = 0, cs_cnt = 0, win_cnt = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        win_cnt = win_cnt + 1;
        bitn = 0;
      end
      if (!cs_n && sck && !prev_sck) begin
        acc = {acc[6:0], mosi};
        bitn = bitn + 1;
        if (bitn == 8) begin
          rx[rx_n] = acc;
          rx_n = rx_n + 1;
          bitn = 0;
        end
      end
      if (busy) busy_cnt = busy_cnt + 1;
      if (!cs_n) cs_cnt = cs_cnt + 1;
      prev_sck = sck;
      prev_cs = cs_n;
    end
  end

  logic [7:0] exp_b [0:199];
  int exp_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int p);
    return 8'((k * 37 + p * 91 + 5) & 255);
  endfunction

  task automatic build_header();
    exp_b[0] = opcode;
    exp_n = 1;
    if (addr4) begin
      exp_b[exp_n] = addr[31:24];
      exp_n = exp_n + 1;
    end
    exp_b[exp_n] = addr[23:16]; exp_n = exp_n + 1;
    exp_b[exp_n] = addr[15:8];  exp_n = exp_n + 1;
    exp_b[exp_n] = addr[7:0];   exp_n = exp_n + 1;
  endtask

  task automatic do_write(input bit exp_err, input bit poke, input string tag);
    int r0 = rx_n;
    int b0 = busy_cnt;
    int c0 = cs_cnt;
    int w0 = win_cnt;
    int bad = 0;
    int first_bad = -1;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      push = 1'b1;
      push_word = 32'hFFFF_0000;
      go = 1'b1;
      @(negedge clk);
      push = 1'b0;
      go = 1'b0;
    end
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    if (exp_err) begin
      chk(underfill == 1'b1, "R7 underfill set", int'(underfill), 1);
      chk(win_cnt == w0, "R7 no select window", win_cnt - w0, 0);
      chk(busy_cnt == b0, "R7 busy stays low", busy_cnt - b0, 0);
    end else begin
      chk(underfill == 1'b0, "R7 underfill cleared", int'(underfill), 0);
      chk(win_cnt - w0 == 1, {tag, " R6 one window"}, win_cnt - w0, 1);
      chk(busy_cnt - b0 == 16 * exp_n + 2, {tag, " R6 busy length"},
          busy_cnt - b0, 16 * exp_n + 2);
      chk(cs_cnt - c0 == 16 * exp_n + 2, {tag, " R6 select length"},
          cs_cnt - c0, 16 * exp_n + 2);
      chk(rx_n - r0 == exp_n, {tag, " byte count"}, rx_n - r0, exp_n);
      for (int i = 0; i < exp_n; i++) begin
        if (rx[r0 + i] !== exp_b[i]) begin
          bad = bad + 1;
          if (first_bad < 0) first_bad = i;
        end
      end
      if (first_bad < 0) begin
        chk(1'b1, tag, 0, 0);
      end else begin
        chk(1'b0, {tag, " byte stream"}, int'(rx[r0 + first_bad]),
            int'(exp_b[first_bad]));
      end
    end
  endtask

  task automatic push_words(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push = 1'b1;
      if (i < 32) push_word = {pat(4*i+3, p), pat(4*i+2, p), pat(4*i+1, p), pat(4*i, p)};
      else push_word = 32'hA5A5_A5A5;
    end
    @(negedge clk) push = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk) mode_req = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sck == 1'b0, "R1 sck", int'(sck), 0);
    chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(underfill == 1'b0, "R1 underfill", int'(underfill), 0);
    chk(mode_ack == 1'b0, "R1 mode_ack", int'(mode_ack), 0);

    // R2 idle handshake: due one edge after the request
    mode_req = 1'b1;
    chk(mode_ack == 1'b0, "R2 not before edge", int'(mode_ack), 0);
    @(negedge clk);
    chk(mode_ack == 1'b1, "R2 one edge later", int'(mode_ack), 1);
    mode_req = 1'b0;
    @(negedge clk);
    chk(mode_ack == 1'b0, "R2 drop one edge later", int'(mode_ack), 0);

    // R5 direct writes, R4 both address widths
    for (int a4 = 0; a4 < 2; a4++) begin
      addr4 = a4[0];
      addr = a4 ? 32'hDEAD_BEEF : 32'h00A1_B2C3;
      sbyte = a4 ? 8'h3C : 8'h5A;
      opcode = 8'h02;
      build_header();
      exp_b[exp_n] = sbyte;
      exp_n = exp_n + 1;
      do_write(1'b0, 1'b0, a4 ? "R5 R4 direct 4-byte" : "R5 R4 direct 3-byte");
    end

    // R2 request during a command is deferred; R10 go while busy ignored
    addr4 = 1'b0;
    build_header();
    exp_b[exp_n] = sbyte;
    exp_n = exp_n + 1;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (20) @(negedge clk);
    mode_req = 1'b1;
    go = 1'b1;
    repeat (10) @(negedge clk);
    go = 1'b0;
    chk(mode_ack == 1'b0, "R2 held while busy", int'(mode_ack), 0);
    while (busy) @(negedge clk);
    chk(mode_ack == 1'b0, "R2 not yet at busy fall", int'(mode_ack), 0);
    @(negedge clk);
    chk(mode_ack == 1'b1, "R2 one edge after busy fall", int'(mode_ack), 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 no restart from go during busy", int'(busy), 0);

    // R9 pushes dropped while mode is off
    set_mode(1'b0);
    push_words(32, 0);
    set_mode(1'b1);
    do_write(1'b1, 1'b0, "R9 pushes with mode off");

    // R3 buffered sweep over address width and pattern; 33rd push dropped (R9)
    for (int a4 = 0; a4 < 2; a4++) begin
      for (int p = 0; p < 2; p++) begin
        addr4 = a4[0];
        addr = 32'h1234_5600 + 32'(p * 256) + 32'(a4 * 32'h0100_0000);
        opcode = p ? 8'h32 : 8'h02;
        push_words(33, p);
        build_header();
        for (int k = 0; k < 128; k++) begin
          exp_b[exp_n] = pat(k, p);
          exp_n = exp_n + 1;
        end
        do_write(1'b0, p[0], p ? "R3 R10 buffered with poke" : "R3 buffered");
        // queue emptied by the burst; pushes during busy were dropped (R9)
        do_write(1'b1, 1'b0, "R9 R7 queue empty after burst");
      end
    end

    // R8 flush on disable
    push_words(32, 3);
    set_mode(1'b0);
    chk(mode_ack == 1'b0, "R8 mode off", int'(mode_ack), 0);
    set_mode(1'b1);
    do_write(1'b1, 1'b0, "R8 flushed queue");

    // R7 underfill cleared by next accepted command
    set_mode(1'b0);
    addr4 = 1'b0;
    addr = 32'h0000_0010;
    sbyte = 8'hC3;
    build_header();
    exp_b[exp_n] = sbyte;
    exp_n = exp_n + 1;
    do_write(1'b0, 1'b0, "R7 R5 clear after underfill");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule